// File: doc/BRIEF.md
# Time-of-Day Counter with Slew and Drift Trim

This block keeps a free-running time of day for precision time stamping: a 48-bit seconds count, a 30-bit nanoseconds count and a 16-bit fraction of a nanosecond below it. On every clock edge the nanosecond part grows by a programmed step. The step is a fixed-point number of nanoseconds with 16 fraction bits. When the nanosecond part reaches one billion, it rolls over and the seconds count goes up by one.

Software steers the clock through a 32-bit word-addressed register port with read and write strobes. A phase error is removed gently by slewing: for a programmed number of cycles a substitute step takes the place of the normal one. A frequency error smaller than one fraction step is trimmed by adding a small extra amount once every programmed number of cycles. A new time is written in three words and takes effect at once when the nanoseconds word is written. A coherent read starts with the nanoseconds word, which also freezes a copy of the seconds for the two reads that follow.

The slew control is a two-state machine. NOMINAL uses the normal step. The transition NOMINAL to SLEW is taken when a nonzero count is written. SLEW uses the substitute step and counts down by one each cycle. The transition SLEW to NOMINAL is taken on the last counted cycle, or when a count of zero is written. A nonzero write made while in SLEW restarts the count and the machine stays in SLEW.

Top module: `tod_clock_core`

## Requirements
- R1: After reset the time (seconds and nanoseconds) is zero, the step word (4) reads RESET_STEP (default 0x80000, 8 ns), and the slew count (6), drift value (7) and drift interval (8) read zero.
- R2: Each clock edge adds the step word (20 bits: nanoseconds << 16 fraction bits) to the {nanoseconds, fraction} value. A step of 0 freezes the time.
- R3: When the nanoseconds value would reach 1,000,000,000 or more, 1,000,000,000 is subtracted and the 48-bit seconds count goes up by one. The carry passes from the low seconds word (1) into the high word (0), and this holds for steps above 1 ns.
- R4: Writes to seconds-high (word 0, bits 15:0) and seconds-low (word 1) are staged and have no visible effect. A write to nanoseconds (word 2) loads all three into the time in one edge and clears the fraction.
- R5: A read of nanoseconds (word 2) captures the seconds at that edge. Later reads of words 1 and 0 return that captured value, even if the seconds have since advanced.
- R6: Writing N to the slew count (word 6) makes the next N edges add the slew step (word 5) instead of the normal step. The count word reads the remaining cycles and reaches 0 when the slew ends.
- R7: With a nonzero drift value (word 7, 16 fraction bits) and a nonzero interval R (word 8), the drift value is added on top of the step once every R edges. The first addition comes R edges after the interval is written.
- R8: A drift value of 0 or an interval of 0 disables the extra addition.
- R9: Word 3 reads 0 and a write to it changes nothing. Unused upper bits read 0, for example bits 31:16 of seconds-high.
- R10: Read data appears on rdata on the edge at which rd_en is sampled and is held until the next read. Addresses 9 to 15 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Time base clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the addressed word |
| rd_en | input | 1 | Read strobe for the addressed word |
| addr | input | 4 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |

## Verification
A table of starting times and steps separates plain accumulation from rollover in several ways. One entry uses an 8 ns step with no wrap. One wraps with a 4 ns step. One uses the largest step, where the fraction must carry into nanoseconds. One uses a 1.5 ns step that crosses both the second and the 32-bit seconds boundary. One uses a zero step, where the time must not move. One entry starts a few nanoseconds before a wrap and reads seconds after the wrap has happened, which only a working snapshot survives. Directed sequences then separate a substitute step from a normal one by the exact nanosecond total after a slew. They separate a correct drift interval from an off-by-one one by the count of half-nanosecond additions. They also show that staged seconds, reserved-word writes and a leftover fraction have no effect where none is required.

// File: rtl/tod_pkg.sv
`timescale 1ns/1ps
package tod_pkg;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 32;
    localparam int NS_W   = 30;
    localparam logic [NS_W-1:0] NS_PER_SEC = 30'd1_000_000_000;

    typedef enum logic [ADDR_W-1:0] {
        WD_SEC_HI     = 4'd0,
        WD_SEC_LO     = 4'd1,
        WD_NSEC       = 4'd2,
        WD_RSVD       = 4'd3,
        WD_STEP       = 4'd4,
        WD_SLEW_STEP  = 4'd5,
        WD_SLEW_CNT   = 4'd6,
        WD_DRIFT      = 4'd7,
        WD_DRIFT_RATE = 4'd8
    } tod_word_e;

    typedef enum logic {
        ST_NOMINAL = 1'b0,
        ST_SLEW    = 1'b1
    } slew_state_e;
endpackage

// File: rtl/tod_csr.sv
`timescale 1ns/1ps
module tod_csr
    import tod_pkg::*;
#(
    parameter int SEC_W   = 48,
    parameter int PER_W   = 20,
    parameter int DRIFT_W = 16,
    parameter int RATE_W  = 16,
    parameter int CNT_W   = 20,
    parameter logic [PER_W-1:0] RESET_STEP = 20'h80000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en_i,
    input  logic                rd_en_i,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic [DATA_W-1:0]   wdata_i,
    input  logic [SEC_W-1:0]    sec_i,
    input  logic [NS_W-1:0]     ns_i,
    input  logic [CNT_W-1:0]    slew_cnt_i,
    output logic [PER_W-1:0]    step_o,
    output logic [PER_W-1:0]    slew_step_o,
    output logic [DRIFT_W-1:0]  drift_o,
    output logic [RATE_W-1:0]   rate_o,
    output logic                rate_wr_o,
    output logic                cnt_load_o,
    output logic [CNT_W-1:0]    cnt_val_o,
    output logic                load_o,
    output logic [SEC_W-1:0]    load_sec_o,
    output logic [NS_W-1:0]     load_ns_o,
    output logic [DATA_W-1:0]   rdata_o
);
    localparam int SEC_HI_W = SEC_W - DATA_W;

    logic [SEC_HI_W-1:0] stage_hi_q;
    logic [DATA_W-1:0]   stage_lo_q;
    logic [SEC_W-1:0]    snap_q;
    logic [DATA_W-1:0]   rd_mux;

    assign load_o     = wr_en_i && (addr_i == WD_NSEC);
    assign load_ns_o  = wdata_i[NS_W-1:0];
    assign load_sec_o = {stage_hi_q, stage_lo_q};
    assign cnt_load_o = wr_en_i && (addr_i == WD_SLEW_CNT);
    assign cnt_val_o  = wdata_i[CNT_W-1:0];
    assign rate_wr_o  = wr_en_i && (addr_i == WD_DRIFT_RATE);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_hi_q  <= '0;
            stage_lo_q  <= '0;
            step_o      <= RESET_STEP;
            slew_step_o <= '0;
            drift_o     <= '0;
            rate_o      <= '0;
        end else if (wr_en_i) begin
            unique case (addr_i)
                WD_SEC_HI:     stage_hi_q  <= wdata_i[SEC_HI_W-1:0];
                WD_SEC_LO:     stage_lo_q  <= wdata_i;
                WD_STEP:       step_o      <= wdata_i[PER_W-1:0];
                WD_SLEW_STEP:  slew_step_o <= wdata_i[PER_W-1:0];
                WD_DRIFT:      drift_o     <= wdata_i[DRIFT_W-1:0];
                WD_DRIFT_RATE: rate_o      <= wdata_i[RATE_W-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        unique case (addr_i)
            WD_SEC_HI:     rd_mux = DATA_W'(snap_q[SEC_W-1:DATA_W]);
            WD_SEC_LO:     rd_mux = snap_q[DATA_W-1:0];
            WD_NSEC:       rd_mux = DATA_W'(ns_i);
            WD_STEP:       rd_mux = DATA_W'(step_o);
            WD_SLEW_STEP:  rd_mux = DATA_W'(slew_step_o);
            WD_SLEW_CNT:   rd_mux = DATA_W'(slew_cnt_i);
            WD_DRIFT:      rd_mux = DATA_W'(drift_o);
            WD_DRIFT_RATE: rd_mux = DATA_W'(rate_o);
            default:       rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_q  <= '0;
            rdata_o <= '0;
        end else if (rd_en_i) begin
            rdata_o <= rd_mux;
            if (addr_i == WD_NSEC) snap_q <= sec_i;
        end
    end

    assert_reserved_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && addr_i == WD_RSVD) |=> (rdata_o == '0));

    assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en_i |=> $stable(rdata_o));
endmodule

// File: rtl/tod_slew_fsm.sv
`timescale 1ns/1ps
module tod_slew_fsm
    import tod_pkg::*;
#(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_load_i,
    input  logic [CNT_W-1:0] cnt_val_i,
    output logic             use_adj_o,
    output logic [CNT_W-1:0] cnt_o
);
    slew_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (cnt_load_i) begin
            cnt_d   = cnt_val_i;
            state_d = (cnt_val_i != '0) ? ST_SLEW : ST_NOMINAL;
        end else begin
            unique case (state_q)
                ST_NOMINAL: ;
                ST_SLEW: begin
                    cnt_d = cnt_q - 1'b1;
                    if (cnt_q == CNT_W'(1)) state_d = ST_NOMINAL;
                end
                default: state_d = ST_NOMINAL;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_NOMINAL;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        use_adj_o = (state_q == ST_SLEW);
        cnt_o     = cnt_q;
    end

    assert_slew_has_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SLEW) |-> (cnt_q != '0));

    assert_slew_countdown_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SLEW && !cnt_load_i) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/tod_drift_tick.sv
`timescale 1ns/1ps
module tod_drift_tick #(
    parameter int DRIFT_W = 16,
    parameter int RATE_W  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [DRIFT_W-1:0] drift_i,
    input  logic [RATE_W-1:0]  rate_i,
    input  logic               rate_wr_i,
    output logic               fire_o
);
    logic [RATE_W-1:0] tick_q;
    logic              active;
    logic              last;

    assign active = (drift_i != '0) && (rate_i != '0);
    assign last   = (tick_q == rate_i - 1'b1);
    assign fire_o = active && last;

    always_ff @(posedge clk) begin
        if (!rst_n || rate_wr_i) tick_q <= '0;
        else if (active)         tick_q <= last ? '0 : tick_q + 1'b1;
    end

    assert_drift_spacing_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_o && rate_i > RATE_W'(1) && !rate_wr_i) |=> !fire_o);
endmodule

// File: rtl/tod_accum.sv
`timescale 1ns/1ps
module tod_accum
    import tod_pkg::*;
#(
    parameter int SEC_W  = 48,
    parameter int FRAC_W = 16,
    parameter int INC_W  = 21
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [SEC_W-1:0] load_sec_i,
    input  logic [NS_W-1:0]  load_ns_i,
    input  logic [INC_W-1:0] inc_i,
    output logic [SEC_W-1:0] sec_o,
    output logic [NS_W-1:0]  ns_o
);
    localparam int ACC_W = NS_W + FRAC_W;
    localparam logic [ACC_W:0] WRAP_AT = (ACC_W+1)'(NS_PER_SEC) << FRAC_W;

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W:0]   sum;
    logic             wrap;

    assign sum  = {1'b0, acc_q} + (ACC_W+1)'(inc_i);
    assign wrap = (sum >= WRAP_AT);
    assign ns_o = acc_q[ACC_W-1:FRAC_W];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            sec_o <= '0;
        end else if (load_i) begin
            acc_q <= {load_ns_i, {FRAC_W{1'b0}}};
            sec_o <= load_sec_i;
        end else if (wrap) begin
            acc_q <= ACC_W'(sum - WRAP_AT);
            sec_o <= sec_o + 1'b1;
        end else begin
            acc_q <= sum[ACC_W-1:0];
        end
    end

    assert_ns_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> (ns_o < NS_PER_SEC));

    assert_sec_single_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> ((sec_o == $past(sec_o)) || (sec_o == $past(sec_o) + 1'b1)));
endmodule

// File: rtl/tod_clock_core.sv
`timescale 1ns/1ps
module tod_clock_core
    import tod_pkg::*;
#(
    parameter int SEC_W   = 48,
    parameter int FRAC_W  = 16,
    parameter int PER_W   = 20,
    parameter int DRIFT_W = 16,
    parameter int RATE_W  = 16,
    parameter int CNT_W   = 20,
    parameter logic [PER_W-1:0] RESET_STEP = 20'h80000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int INC_W = PER_W + 1;

    logic [SEC_W-1:0]   sec;
    logic [NS_W-1:0]    ns;
    logic [CNT_W-1:0]   slew_cnt;
    logic [PER_W-1:0]   step, slew_step;
    logic [DRIFT_W-1:0] drift;
    logic [RATE_W-1:0]  rate;
    logic               rate_wr, cnt_load, load, use_adj, fire;
    logic [CNT_W-1:0]   cnt_val;
    logic [SEC_W-1:0]   load_sec;
    logic [NS_W-1:0]    load_ns;
    logic [INC_W-1:0]   inc;

    assign inc = INC_W'(use_adj ? slew_step : step)
               + (fire ? INC_W'(drift) : INC_W'(0));

    tod_csr #(
        .SEC_W(SEC_W), .PER_W(PER_W), .DRIFT_W(DRIFT_W),
        .RATE_W(RATE_W), .CNT_W(CNT_W), .RESET_STEP(RESET_STEP)
    ) u_csr (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
        .addr_i(addr), .wdata_i(wdata), .sec_i(sec), .ns_i(ns),
        .slew_cnt_i(slew_cnt), .step_o(step), .slew_step_o(slew_step),
        .drift_o(drift), .rate_o(rate), .rate_wr_o(rate_wr),
        .cnt_load_o(cnt_load), .cnt_val_o(cnt_val), .load_o(load),
        .load_sec_o(load_sec), .load_ns_o(load_ns), .rdata_o(rdata)
    );

    tod_slew_fsm #(.CNT_W(CNT_W)) u_slew (
        .clk(clk), .rst_n(rst_n), .cnt_load_i(cnt_load),
        .cnt_val_i(cnt_val), .use_adj_o(use_adj), .cnt_o(slew_cnt)
    );

    tod_drift_tick #(.DRIFT_W(DRIFT_W), .RATE_W(RATE_W)) u_drift (
        .clk(clk), .rst_n(rst_n), .drift_i(drift), .rate_i(rate),
        .rate_wr_i(rate_wr), .fire_o(fire)
    );

    tod_accum #(.SEC_W(SEC_W), .FRAC_W(FRAC_W), .INC_W(INC_W)) u_accum (
        .clk(clk), .rst_n(rst_n), .load_i(load), .load_sec_i(load_sec),
        .load_ns_i(load_ns), .inc_i(inc), .sec_o(sec), .ns_o(ns)
    );
endmodule

// File: tb/tod_clock_core_tb_top.sv
`timescale 1ns/1ps
module tod_clock_core_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    tod_clock_core dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata)
    );

    // Columns: step, sec_hi, sec_lo, ns, advances, exp_hi, exp_lo, exp_ns
    localparam logic [31:0] VEC [6][8] = '{
        '{32'h80000, 32'h0,        32'd5,        32'd100,         32'd10, 32'h0,    32'd5,  32'd180},
        '{32'h40000, 32'hABCD1234, 32'd7,        32'd999_999_990, 32'd3,  32'h1234, 32'd8,  32'd2},
        '{32'hFFFFF, 32'h0,        32'd0,        32'd0,           32'd4,  32'h0,    32'd0,  32'd63},
        '{32'h18000, 32'h0,        32'hFFFFFFFF, 32'd999_999_999, 32'd2,  32'h1,    32'h0,  32'd2},
        '{32'h0,     32'h0,        32'd9,        32'd42,          32'd5,  32'h0,    32'd9,  32'd42},
        '{32'h40000, 32'h0,        32'd20,       32'd999_999_996, 32'd0,  32'h0,    32'd20, 32'd999_999_996}
    };

    task automatic check(input string what, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", what, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] q);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        q = rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] q;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(4'd2, q); check("R1 ns after reset", q, 32'd0);
        rd(4'd1, q); check("R1 sec_lo after reset", q, 32'd0);
        rd(4'd4, q); check("R1 step reset value", q, 32'h80000);
        rd(4'd6, q); check("R1 slew count reset", q, 32'd0);
        rd(4'd8, q); check("R1 drift interval reset", q, 32'd0);

        // R2 R3 R5 R9 vector table
        for (int i = 0; i < 6; i++) begin
            wr(4'd4, VEC[i][0]);
            wr(4'd0, VEC[i][1]);
            wr(4'd1, VEC[i][2]);
            wr(4'd2, VEC[i][3]);
            idle(int'(VEC[i][4]));
            rd(4'd2, q); check($sformatf("R2 R3 vec%0d ns", i), q, VEC[i][7]);
            rd(4'd1, q); check($sformatf("R3 R5 vec%0d sec_lo", i), q, VEC[i][6]);
            rd(4'd0, q); check($sformatf("R3 R9 vec%0d sec_hi", i), q, VEC[i][5]);
        end

        // R4 fraction cleared on load
        wr(4'd4, 32'h18000);
        wr(4'd4, 32'h08000);
        wr(4'd0, 32'd0);
        wr(4'd1, 32'd3);
        wr(4'd2, 32'd500);
        rd(4'd2, q); check("R4 load value", q, 32'd500);
        rd(4'd2, q); check("R4 fraction cleared", q, 32'd500);
        wr(4'd4, 32'd0);             // time now frozen at 501
        // R4 staging has no effect until ns write
        wr(4'd0, 32'd0);
        wr(4'd1, 32'd77);
        rd(4'd2, q); check("R4 staged ns untouched", q, 32'd501);
        rd(4'd1, q); check("R4 staged sec_lo not applied", q, 32'd3);
        // R9 reserved word
        wr(4'd3, 32'hFFFFFFFF);
        rd(4'd3, q); check("R9 reserved reads zero", q, 32'd0);
        rd(4'd2, q); check("R9 reserved write ignored", q, 32'd501);
        // R10 unmapped address
        rd(4'd12, q); check("R10 unmapped reads zero", q, 32'd0);
        // R4 atomic load
        wr(4'd2, 32'd600);
        rd(4'd2, q); check("R4 ns loaded", q, 32'd600);
        rd(4'd1, q); check("R4 sec_lo loaded", q, 32'd77);

        // R6 slew
        wr(4'd4, 32'h10000);
        wr(4'd2, 32'd0);
        wr(4'd5, 32'h30000);
        wr(4'd6, 32'd5);
        rd(4'd6, q); check("R6 count after write", q, 32'd5);
        idle(9);
        rd(4'd2, q); check("R6 ns after slew", q, 32'd22);
        rd(4'd6, q); check("R6 count drained", q, 32'd0);

        // R7 drift every 4 cycles
        wr(4'd2, 32'd0);
        wr(4'd7, 32'h8000);
        wr(4'd8, 32'd4);
        idle(16);
        rd(4'd2, q); check("R7 ns with drift", q, 32'd20);

        // R8 interval zero disables
        wr(4'd8, 32'd0);
        wr(4'd2, 32'd0);
        idle(8);
        rd(4'd2, q); check("R8 interval zero", q, 32'd8);
        // R8 drift value zero disables
        wr(4'd8, 32'd2);
        wr(4'd7, 32'd0);
        wr(4'd2, 32'd0);
        idle(8);
        rd(4'd2, q); check("R8 drift zero", q, 32'd8);

        finish_run();
    end
endmodule